// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates eleven interrupt request flags for an 8051-style CPU and tracks nesting. Each source has an enable bit and a 2-bit priority code. A global enable gates every source. On each clock the controller picks the eligible request with the highest priority, breaking ties by source number. It forwards that request only when its level is strictly above every level already in service.

When a request is taken, the controller raises a one-cycle request pulse to the CPU. In the same cycle it shows the source index and the vector address, and it sends a one-hot acknowledge so the peripheral can clear its flag. The level of the taken request is added to a 4-bit in-service mask. A return-from-interrupt strobe from the CPU removes the highest level in that mask, so the interrupted context can resume. Requests that were held back then compete again.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, irq_o is 0, ack_o is all zeros, vec_idx_o and vec_addr_o are 0, and in_svc_o is 0.
- R2: A source takes part in arbitration only when its flag in req_i, its bit in en_i and gen_i are all 1. Any other source is never acknowledged.
- R3: Source i's priority is prio_i[2i+1:2i]. Code 3 is the highest and code 0 the lowest. The eligible source with the highest code wins.
- R4: Among eligible sources with the same winning code, the lowest source index wins.
- R5: A winner is taken only if its code is strictly greater than the highest set bit of in_svc_o, or if in_svc_o is zero. Otherwise it stays pending with no output activity.
- R6: A request that is taken at a clock edge produces, for the cycle after that edge: irq_o=1, ack_o with only bit i set, vec_idx_o=i, and bit p of in_svc_o set, where p is the winner's code.
- R7: vec_addr_o equals 8*vec_idx_o+3 whenever irq_o is 1.
- R8: A clock edge with reti_i=1 clears the highest set bit of in_svc_o. With in_svc_o at zero it leaves the mask unchanged. No request is taken at that edge.
- R9: After a release, a pending request whose code is now above the remaining highest in-service level is taken at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 11 | Request flags, bit i = source i |
| en_i | input | 11 | Per-source enable |
| gen_i | input | 1 | Global enable |
| prio_i | input | 22 | 2-bit priority code per source, source i at [2i+1:2i] |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | One-cycle request pulse to the CPU |
| vec_idx_o | output | 4 | Index of the source being vectored |
| vec_addr_o | output | 7 | Vector address, 8*index+3 |
| ack_o | output | 11 | One-hot acknowledge to the chosen source |
| in_svc_o | output | 4 | In-service mask, bit p = level p active |

## Verification
A corrupted in-service mask shows at the ports in one of two ways. A request that should preempt is never raised. Or a request at a level already in service is raised a second time. Either case appears on irq_o in the cycle after the faulty edge, and in_svc_o shows the bad mask at once. A wrong arbitration result shows on vec_idx_o and ack_o in the same cycle as the pulse. A lost release stalls every held-back request for good. The bench compares all outputs with a behavioural model on every cycle, so each of these faults is caught within one clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned VEC_STRIDE = 8;
  localparam int unsigned VEC_OFFSET = 3;

  function automatic int unsigned vec_addr_of(input int unsigned idx);
    return idx * VEC_STRIDE + VEC_OFFSET;
  endfunction
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned LVL_W   = 2,
  parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC-1:0]       en_i,
  input  logic                     gen_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  output logic                     win_vld_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output logic [LVL_W-1:0]         win_lvl_o
);
  logic [NUM_SRC-1:0] elig;
  assign elig = req_i & en_i & {NUM_SRC{gen_i}};

  // strict > keeps the lowest index among equal levels
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_vld_o || prio_i[i*LVL_W +: LVL_W] > win_lvl_o)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = prio_i[i*LVL_W +: LVL_W];
      end
    end
  end

  a_r2_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> (req_i[win_idx_o] && en_i[win_idx_o] && gen_i));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    a_r3_no_higher_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig[g] |-> (win_vld_o && prio_i[g*LVL_W +: LVL_W] <= win_lvl_o));
    a_r4_tie_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig[g] && win_vld_o && prio_i[g*LVL_W +: LVL_W] == win_lvl_o) |-> (IDX_W'(g) >= win_idx_o));
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack #(
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned NUM_LVL = 1 << LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [LVL_W-1:0]   set_lvl_i,
  input  logic               pop_i,
  output logic [NUM_LVL-1:0] mask_o,
  output logic               top_vld_o,
  output logic [LVL_W-1:0]   top_lvl_o
);
  logic [NUM_LVL-1:0] mask_q, mask_d;

  always_comb begin
    top_vld_o = 1'b0;
    top_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (mask_q[l]) begin
        top_vld_o = 1'b1;
        top_lvl_o = LVL_W'(l);
      end
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (pop_i && top_vld_o) mask_d[top_lvl_o] = 1'b0;
    if (set_i)              mask_d[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  a_r5_set_above_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> (!top_vld_o || set_lvl_i > top_lvl_o));
  a_r8_pop_removes_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && top_vld_o) |=> ($countones(mask_o) == $countones($past(mask_o)) - 1));
  a_r8_pop_empty_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !top_vld_o) |=> (mask_o == '0));
  a_r8_no_set_on_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && pop_i));
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned IDX_W   = $clog2(NUM_SRC),
  parameter int unsigned ADDR_W  = IDX_W + 3
) (
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [NUM_SRC-1:0] sel_o
);
  assign addr_o = ADDR_W'(irq_pkg::vec_addr_of(32'(idx_i)));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
    assign sel_o[g] = (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned NUM_LVL = 1 << LVL_W,
  localparam int unsigned IDX_W   = $clog2(NUM_SRC),
  localparam int unsigned ADDR_W  = IDX_W + $clog2(irq_pkg::VEC_STRIDE)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC-1:0]       en_i,
  input  logic                     gen_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  input  logic                     reti_i,
  output logic                     irq_o,
  output logic [IDX_W-1:0]         vec_idx_o,
  output logic [ADDR_W-1:0]        vec_addr_o,
  output logic [NUM_SRC-1:0]       ack_o,
  output logic [NUM_LVL-1:0]       in_svc_o
);
  logic               win_vld;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;
  logic               top_vld;
  logic [LVL_W-1:0]   top_lvl;
  logic               take;
  logic [ADDR_W-1:0]  enc_addr;
  logic [NUM_SRC-1:0] enc_sel;

  irq_prio_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i), .en_i(en_i), .gen_i(gen_i), .prio_i(prio_i),
    .win_vld_o(win_vld), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  // release has precedence: no new entry on a RETI edge
  assign take = win_vld && !reti_i && (!top_vld || win_lvl > top_lvl);

  irq_svc_stack #(.LVL_W(LVL_W)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(take), .set_lvl_i(win_lvl), .pop_i(reti_i),
    .mask_o(in_svc_o), .top_vld_o(top_vld), .top_lvl_o(top_lvl)
  );

  irq_vec_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_enc (
    .idx_i(win_idx), .addr_o(enc_addr), .sel_o(enc_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      vec_idx_o  <= '0;
      vec_addr_o <= '0;
      ack_o      <= '0;
    end else begin
      irq_o      <= take;
      vec_idx_o  <= take ? win_idx  : '0;
      vec_addr_o <= take ? enc_addr : '0;
      ack_o      <= take ? enc_sel  : '0;
    end
  end

  a_r6_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($countones(ack_o) == 1 && ack_o[vec_idx_o]));
  a_r6_ack_only_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (ack_o == '0));
  a_r6_level_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (in_svc_o != '0));
  a_r7_vec_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_addr_o[2:0] == 3'(irq_pkg::VEC_OFFSET)));
  a_r8_no_take_on_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !irq_o);
  a_r2_gen_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_i |=> !irq_o);
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req = '0, en = '0;
  logic          gen = 1'b0, reti = 1'b0;
  logic [2*NS-1:0] prio = '0;
  logic          irq_o;
  logic [3:0]    vec_idx_o, in_svc_o;
  logic [6:0]    vec_addr_o;
  logic [NS-1:0] ack_o;

  int errors = 0, checks = 0;
  string cur_tag = "R1";

  // behavioural reference
  int m_irq, m_idx, m_addr, m_ack, m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en), .gen_i(gen),
    .prio_i(prio), .reti_i(reti), .irq_o(irq_o), .vec_idx_o(vec_idx_o),
    .vec_addr_o(vec_addr_o), .ack_o(ack_o), .in_svc_o(in_svc_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq = 0; m_idx = 0; m_addr = 0; m_ack = 0; m_mask = 0;
    end else begin
      int top, best, bl;
      m_irq = 0; m_idx = 0; m_addr = 0; m_ack = 0;
      if (reti) begin
        for (int l = 3; l >= 0; l--) if (m_mask[l]) begin m_mask[l] = 1'b0; break; end
      end else begin
        top = -1; best = -1; bl = -1;
        for (int l = 0; l < 4; l++) if (m_mask[l]) top = l;
        for (int i = 0; i < NS; i++)
          if (req[i] && en[i] && gen && int'(prio[2*i +: 2]) > bl) begin
            bl = int'(prio[2*i +: 2]); best = i;
          end
        if (best >= 0 && bl > top) begin
          m_irq = 1; m_idx = best; m_addr = 8*best + 3; m_ack = 1 << best;
          m_mask[bl] = 1'b1;
        end
      end
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("irq", int'(irq_o), m_irq);
    check("ack", int'(ack_o), m_ack);
    check("idx", int'(vec_idx_o), m_idx);
    check("addr R7", int'(vec_addr_o), m_addr);
    check("in_svc", int'(in_svc_o), m_mask);
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
      req = req & ~ack_o;  // peripheral clears its flag on acknowledge
    end
  endtask

  task automatic set_prio(input int s, input int p);
    prio[2*s +: 2] = 2'(p);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_tag = "R1";
    req = '1; en = '1; gen = 1'b1;
    repeat (2) begin @(negedge clk); compare_all(); end
    req = '0; en = '0; gen = 1'b0;
    rst_n = 1'b1;
    tick(2);

    // R2 global gate and per-source enable
    cur_tag = "R2";
    req = '1; en = '1; gen = 1'b0;
    tick(3);
    check("R2 held flags", int'(req), 32'h7FF);
    gen = 1'b1; en = '0; req = 11'h008;
    tick(3);
    check("R2 disabled src3 flag kept", int'(req[3]), 1);
    req = '0;
    tick(1);

    // R3 highest code wins
    cur_tag = "R3";
    en = '1;
    set_prio(2, 1); set_prio(7, 3); set_prio(9, 2);
    req = 11'h284;  // sources 2, 7, 9
    tick(1);
    check("R3 winner idx", int'(vec_idx_o), 7);
    check("R3 mask level3", int'(in_svc_o), 8);

    // R5 lower codes held back while level 3 in service
    cur_tag = "R5";
    tick(3);
    check("R5 src9 pending", int'(req[9]), 1);
    check("R5 src2 pending", int'(req[2]), 1);

    // R8 + R9 release then resume
    cur_tag = "R8";
    reti = 1'b1; tick(1); reti = 1'b0;
    check("R8 mask after release", int'(in_svc_o), 0);
    cur_tag = "R9";
    tick(1);
    check("R9 resumed src9", int'(vec_idx_o), 9);
    tick(1);
    check("R9 src2 still held", int'(irq_o), 0);
    reti = 1'b1; tick(1); reti = 1'b0;
    tick(1);
    check("R9 src2 taken", int'(vec_idx_o), 2);
    check("R7 addr of src2", int'(vec_addr_o), 19);
    reti = 1'b1; tick(1); reti = 1'b0;

    // R8 release with empty mask
    cur_tag = "R8";
    reti = 1'b1; tick(2); reti = 1'b0;
    check("R8 empty release", int'(in_svc_o), 0);

    // R4 tie: lowest index first, nested preemption by higher level
    cur_tag = "R4";
    prio = '0; set_prio(4, 2); set_prio(6, 2); set_prio(10, 3);
    req = 11'h050;
    tick(1);
    check("R4 tie winner", int'(vec_idx_o), 4);
    tick(1);
    check("R4 equal level blocked", int'(irq_o), 0);
    cur_tag = "R6";
    req[10] = 1'b1;
    tick(1);
    check("R6 preempt by level3", int'(ack_o), 1 << 10);
    check("R6 nested mask", int'(in_svc_o), 12);
    tick(1);
    check("R6 single pulse", int'(irq_o), 0);

    // R8 release coinciding with pending request: no take on that edge
    cur_tag = "R8";
    reti = 1'b1; tick(1); reti = 1'b0;
    check("R8 no take on reti edge", int'(irq_o), 0);
    reti = 1'b1; tick(1); reti = 1'b0;
    tick(1);
    check("R4 second of tie", int'(vec_idx_o), 6);
    reti = 1'b1; tick(1); reti = 1'b0;
    tick(1);

    // mixed traffic against the model
    cur_tag = "R5";
    for (int s = 0; s < NS; s++) set_prio(s, $urandom_range(0, 3));
    for (int c = 0; c < 400; c++) begin
      req = req | 11'($urandom_range(0, 2047) & $urandom_range(0, 2047));
      en = 11'($urandom_range(0, 2047) | 11'h555);
      gen = ($urandom_range(0, 15) != 0);
      reti = ($urandom_range(0, 5) == 0);
      tick(1);
    end
    reti = 1'b0;
    tick(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule